// File: doc/BRIEF.md
# Receive Interrupt Coalescing Watchdog

This block sits next to the receive DMA of a network interface and holds back the receive interrupt for frames whose descriptors ask for no immediate interrupt. When such a frame finishes, a countdown starts. Once the countdown runs out, the receive status bit is raised, so a burst of quiet frames still produces an interrupt within a bounded time. A frame whose descriptor does allow the interrupt raises the status bit at once and cancels any countdown in progress. The block therefore acts as a coalescing timeout and not as a free-running watchdog.

Software programs an 8-bit delay value. The delay is that value times 256 clock cycles, counted by an 8-bit prescaler and an 8-bit main counter. A value of zero disables the countdown. The status bit is cleared by writing one to it. The interrupt line is the status bit gated by an enable bit that software controls.

Top module: `rx_irq_coalesce`

## Requirements
- R1: After reset the delay register reads 0, the interrupt enable is 0, and the status bit and irq are both 0.
- R2: A write to the delay register stores the 8-bit value, and `delay_q` shows it from the next cycle.
- R3: A quiet frame (frm_done=1, frm_quiet=1) seen at clock edge E0 with a non-zero delay N sets the status bit at edge E0+N*256 and no earlier.
- R4: With a delay of 0, a quiet frame starts no countdown. Writing 0 to the delay register during a countdown stops it at once, and no interrupt follows.
- R5: A normal frame (frm_done=1, frm_quiet=0) sets the status bit at the next edge and cancels any countdown in progress.
- R6: A quiet frame that arrives during a countdown reloads it, so the status bit is set N*256 cycles after the later frame.
- R7: A pulse on sts_clr clears the status bit at the next edge. If a set and a clear fall in the same cycle, the set wins.
- R8: After a countdown expires the timer is idle. Clearing the status bit afterwards does not start it again.
- R9: irq is 1 exactly when the status bit and the interrupt enable are both 1.
- R10: When a normal frame falls on the same edge at which the countdown expires, the status bit is set and the timer ends up idle, with no second interrupt afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_wr | input | 1 | Write strobe for the delay register |
| delay_wdata | input | 8 | Delay value to write, in units of 256 cycles |
| delay_q | output | 8 | Current delay register value |
| ien_wr | input | 1 | Write strobe for the interrupt enable |
| ien_wdata | input | 1 | Interrupt enable value to write |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| frm_done | input | 1 | Receive DMA finished a frame (one-cycle pulse) |
| frm_quiet | input | 1 | The finished frame's descriptor suppresses its interrupt |
| rx_status | output | 1 | Receive interrupt status bit |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a normal frame that lands on exactly the edge at which the countdown expires. No output shows where the counters stand, so the bench gets there by counting cycles. It issues a quiet frame with a delay of one unit, waits 255 cycles, and drives the normal frame so that it is sampled on the 256th edge. It then clears the status bit and waits well past another full delay to show that no second interrupt appears. The reload and stop cases use the same counting method and are checked one cycle either side of the original deadline.

// File: rtl/rxw_pkg.sv
// Package rxw_pkg
// Shared widths and the command bundle that the top passes to the countdown.
// Assumes an 8-bit delay register and an 8-bit prescaler (256 cycles per unit).
package rxw_pkg;
    localparam int DELAY_W = 8;
    localparam int PRE_W   = 8;

    typedef struct packed {
        logic arm;     // quiet frame with non-zero delay: load and start
        logic cancel;  // normal frame raised the status bit: go idle
        logic stop;    // software wrote zero to the delay register: go idle
    } tmr_cmd_t;
endpackage

// File: rtl/rxw_cfg_regs.sv
// Module rxw_cfg_regs
// Holds the software delay value and the interrupt enable bit.
// Assumes the write strobes are one-cycle pulses in the clk domain.
module rxw_cfg_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          delay_wr,
    input  logic [DW-1:0] delay_wdata,
    input  logic          ien_wr,
    input  logic          ien_wdata,
    output logic [DW-1:0] delay_q,
    output logic          ien_q
);
    // Delay register: loaded on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        delay_q <= '0;
        else if (delay_wr) delay_q <= delay_wdata;
    end

    // Interrupt enable: loaded on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        delay_wr |=> (delay_q == $past(delay_wdata)));
endmodule

// File: rtl/rxw_timer.sv
// Module rxw_timer
// Prescaled countdown: the prescaler wraps every 2**PW cycles and the main
// counter, loaded with load_val-1, drops by one at each wrap. The expire pulse
// marks the cycle in which the main counter is zero and the prescaler wraps.
// Assumes load_val is non-zero whenever cmd.arm is set. Priority is
// stop/cancel, then arm, then expiry.
module rxw_timer
    import rxw_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_cmd_t      cmd,
    input  logic [DW-1:0] load_val,
    output logic          running,
    output logic          expire
);
    localparam logic [PW-1:0] PRE_LAST = {PW{1'b1}};

    logic [PW-1:0] pre_q;
    logic [DW-1:0] main_q;
    logic          wrap;

    // Wrap and expiry detection; arm or stop in the same cycle overrides expiry.
    always_comb begin
        wrap   = running && (pre_q == PRE_LAST);
        expire = wrap && (main_q == '0) && !cmd.stop && !cmd.arm;
    end

    // Countdown state: idle, load, or advance the prescaler and main counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pre_q   <= '0;
            main_q  <= '0;
        end else if (cmd.stop || cmd.cancel) begin
            running <= 1'b0;
            pre_q   <= '0;
            main_q  <= '0;
        end else if (cmd.arm) begin
            running <= 1'b1;
            pre_q   <= '0;
            main_q  <= load_val - 1'b1;
        end else if (wrap && (main_q == '0)) begin
            running <= 1'b0;
            pre_q   <= '0;
            main_q  <= '0;
        end else if (running) begin
            pre_q <= pre_q + 1'b1;
            if (wrap) main_q <= main_q - 1'b1;
        end
    end

    assert_run_needs_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (load_val != '0));
    assert_stop_goes_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.stop |=> !running);
    assert_cancel_goes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cancel |=> !running);
    assert_reload_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.arm && !cmd.stop && !cmd.cancel) |=> (running && pre_q == '0));
    assert_idle_prescaler_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pre_q == '0));
    assert_expiry_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !running);
endmodule

// File: rtl/rxw_status.sv
// Module rxw_status
// Receive status bit with write-one-to-clear, and the gated interrupt output.
// Assumes set and clear are one-cycle requests; a set beats a clear.
module rxw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic ien,
    output logic status_q,
    output logic irq_o
);
    // Status bit update: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= 1'b0;
        else if (set_req) status_q <= 1'b1;
        else if (clr_req) status_q <= 1'b0;
    end

    // Interrupt output gating.
    always_comb irq_o = status_q & ien;

    assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> status_q);
    assert_clear_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !status_q);
    assert_rise_needs_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(set_req));
endmodule

// File: rtl/rx_irq_coalesce.sv
// Module rx_irq_coalesce
// Top of the receive interrupt coalescing watchdog. It decodes frame events
// and software writes into timer commands and status requests.
// Assumes frm_done is a one-cycle pulse and frm_quiet is valid with it.
module rx_irq_coalesce
    import rxw_pkg::*;
#(
    parameter int DW = rxw_pkg::DELAY_W,
    parameter int PW = rxw_pkg::PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          delay_wr,
    input  logic [DW-1:0] delay_wdata,
    output logic [DW-1:0] delay_q,
    input  logic          ien_wr,
    input  logic          ien_wdata,
    input  logic          sts_clr,
    input  logic          frm_done,
    input  logic          frm_quiet,
    output logic          rx_status,
    output logic          irq
);
    logic     ien_q;
    logic     tmr_running;
    logic     tmr_expire;
    logic     frm_normal;
    tmr_cmd_t cmd;

    // Event decode: classify the frame and the software writes.
    always_comb begin
        frm_normal = frm_done && !frm_quiet;
        cmd.cancel = frm_normal;
        cmd.stop   = delay_wr && (delay_wdata == '0);
        cmd.arm    = frm_done && frm_quiet && (delay_q != '0);
    end

    rxw_cfg_regs #(.DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .delay_wr(delay_wr), .delay_wdata(delay_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .delay_q(delay_q), .ien_q(ien_q)
    );

    rxw_timer #(.DW(DW), .PW(PW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .load_val(delay_q),
        .running(tmr_running), .expire(tmr_expire)
    );

    rxw_status u_sts (
        .clk(clk), .rst_n(rst_n),
        .set_req(tmr_expire || frm_normal), .clr_req(sts_clr),
        .ien(ien_q), .status_q(rx_status), .irq_o(irq)
    );

    assert_normal_frame_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frm_normal |=> rx_status);
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);
    assert_coincide_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_normal && tmr_running) |=> (rx_status && !tmr_running));
endmodule

// File: tb/rx_irq_coalesce_test.sv
`timescale 1ns/1ps
module rx_irq_coalesce_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       delay_wr, ien_wr, ien_wdata, sts_clr, frm_done, frm_quiet;
    logic [7:0] delay_wdata, delay_q;
    logic       rx_status, irq;
    int         n_chk = 0;
    int         n_fail = 0;

    localparam int NVEC = 4;
    localparam logic [7:0] VEC_DELAY [NVEC] = '{8'd1, 8'd2, 8'd3, 8'd4};

    always #2.5 clk = ~clk;

    rx_irq_coalesce uut (
        .clk(clk), .rst_n(rst_n), .delay_wr(delay_wr), .delay_wdata(delay_wdata),
        .delay_q(delay_q), .ien_wr(ien_wr), .ien_wdata(ien_wdata), .sts_clr(sts_clr),
        .frm_done(frm_done), .frm_quiet(frm_quiet), .rx_status(rx_status), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_delay(input logic [7:0] v);
        delay_wr = 1'b1; delay_wdata = v;
        @(negedge clk);
        delay_wr = 1'b0;
    endtask

    task automatic wr_ien(input logic v);
        ien_wr = 1'b1; ien_wdata = v;
        @(negedge clk);
        ien_wr = 1'b0;
    endtask

    task automatic clr_sts();
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    // Frame pulse; on return the sampling edge E0 has just passed.
    task automatic frame(input logic quiet, input logic with_clr);
        frm_done = 1'b1; frm_quiet = quiet; sts_clr = with_clr;
        @(negedge clk);
        frm_done = 1'b0; frm_quiet = 1'b0; sts_clr = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; delay_wr = 0; delay_wdata = 0; ien_wr = 0; ien_wdata = 0;
        sts_clr = 0; frm_done = 0; frm_quiet = 0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        check("R1 delay", delay_q, 0);
        check("R1 status", rx_status, 0);
        check("R1 irq", irq, 0);

        // R2: register write and readback
        wr_delay(8'hA5);
        check("R2 readback", delay_q, 8'hA5);
        wr_ien(1'b1);

        // Table of delay values: timeout lands on edge E0+N*256 (R3), irq follows (R9)
        for (int i = 0; i < NVEC; i++) begin
            wr_delay(VEC_DELAY[i]);
            clr_sts();
            frame(1'b1, 1'b0);
            wait_cyc(int'(VEC_DELAY[i]) * 256 - 1);
            check("R3 not yet", rx_status, 0);
            wait_cyc(1);
            check("R3 expired", rx_status, 1);
            check("R9 irq on", irq, 1);
            clr_sts();
            check("R7 cleared", rx_status, 0);
            wait_cyc(int'(VEC_DELAY[i]) * 256 + 10);
            check("R8 no restart", rx_status, 0);
        end

        // R4: zero delay does not arm
        wr_delay(8'd0);
        frame(1'b1, 1'b0);
        wait_cyc(300);
        check("R4 zero no arm", rx_status, 0);
        // R4: writing zero mid-count stops it
        wr_delay(8'd1);
        frame(1'b1, 1'b0);
        wait_cyc(100);
        wr_delay(8'd0);
        wait_cyc(300);
        check("R4 stopped", rx_status, 0);

        // R5: a normal frame sets at once and cancels
        wr_delay(8'd2);
        frame(1'b1, 1'b0);
        wait_cyc(100);
        frame(1'b0, 1'b0);
        check("R5 immediate", rx_status, 1);
        clr_sts();
        wait_cyc(600);
        check("R5 cancelled", rx_status, 0);

        // R6: a second quiet frame reloads
        wr_delay(8'd1);
        frame(1'b1, 1'b0);
        wait_cyc(200);
        frame(1'b1, 1'b0);
        wait_cyc(255);
        check("R6 reload holds", rx_status, 0);
        wait_cyc(1);
        check("R6 reload expiry", rx_status, 1);

        // R7: set wins over a simultaneous clear
        clr_sts();
        frame(1'b0, 1'b1);
        check("R7 set wins", rx_status, 1);

        // R9: enable gating
        wr_ien(1'b0);
        check("R9 irq gated", irq, 0);
        wr_ien(1'b1);
        check("R9 irq ungated", irq, 1);

        // R10: a normal frame on the expiry edge
        clr_sts();
        frame(1'b1, 1'b0);
        wait_cyc(255);
        frame(1'b0, 1'b0);
        check("R10 set", rx_status, 1);
        clr_sts();
        wait_cyc(600);
        check("R10 idle after", rx_status, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule